// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves branch instructions for a 64-bit integer datapath. For each accepted operation it evaluates one of eight tests on a 64-bit register value. It forms the branch destination from the already-incremented program counter and a 21-bit signed word offset. It also produces the return address that a jump-and-link writes back, and a static guess of the branch direction for the fetch stage. There are no delay slots. A taken result means that nothing fetched after the branch may execute, and the fetch stage redirects to the target.

The same test logic also serves conditional moves. For a conditional move the unit returns either the candidate source value or the unchanged old destination value. It never signals a redirect for a move. Register index 31 is the hard-wired zero register, so a link aimed at it is dropped.

Results appear on registered outputs one clock after an input cycle with `in_valid` high. The result registers load only on such cycles and otherwise hold their contents. The asynchronous active-low reset is released through a two-stage synchroniser inside the unit.

Top module: `brc_unit`

## Requirements
- R1: For a conditional branch (`in_kind` = 0), `out_taken` equals the selected test on `in_test_val`, taken as signed 64-bit: `in_test` 0 is equal to zero, 1 is not zero, 2 is negative, 3 is negative or zero, 4 is strictly positive, 5 is zero or positive.
- R2: `in_test` 6 (even) is true when bit 0 of `in_test_val` is 0, and 7 (odd) is true when bit 0 is 1; no other bit affects them.
- R3: `out_target` equals `in_next_pc` plus the displacement shifted left by two and sign-extended to 64 bits, modulo 2^64. This gives a reach from -4 MiB to +4 MiB-4, and an aligned `in_next_pc` gives a target whose two low bits are zero.
- R4: An unconditional branch (`in_kind` = 1) is always taken, and `out_link_val` carries `in_next_pc` as the return address.
- R5: `out_link_we` is 1 only for an unconditional branch whose `in_dest` is not 31. For every other kind, and for a destination of 31, it is 0.
- R6: `out_pred_taken` is 1 for an unconditional branch and for a conditional branch with a negative displacement (bit 20 set). It is 0 for a conditional branch with a forward or zero displacement, and 0 for kinds 2 and 3.
- R7: For a conditional move (`in_kind` = 2), `out_move_val` is `in_move_src` when the selected test holds and `in_move_old` otherwise, and `out_taken` is 0. For all other kinds, `out_move_val` is `in_move_old`.
- R8: Results appear one cycle after `in_valid` is high, with `out_valid` high. In a cycle where `in_valid` is low, `out_valid` goes low the cycle after, and every other output keeps its value whatever the inputs do.
- R9: While reset is asserted, and after it is released until the first valid input, every output is 0.
- R10: `in_kind` = 3 is a no-op: not taken, no link write, no predicted-taken, and `out_move_val` equals `in_move_old`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present; enables the result registers |
| in_kind | input | 2 | 0 conditional branch, 1 unconditional branch, 2 conditional move, 3 no-op |
| in_test | input | 3 | Test select (R1, R2 encodings) |
| in_next_pc | input | 64 | Branch address plus 4 |
| in_disp | input | 21 | Signed word displacement |
| in_test_val | input | 64 | Value of the tested register |
| in_dest | input | 5 | Destination register index |
| in_move_src | input | 64 | Candidate value for a conditional move |
| in_move_old | input | 64 | Current destination value for a conditional move |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| out_taken | output | 1 | Branch resolved taken; redirect fetch |
| out_target | output | 64 | Branch destination address |
| out_link_we | output | 1 | Write the return address to the destination |
| out_link_val | output | 64 | Return address |
| out_pred_taken | output | 1 | Static direction guess |
| out_move_val | output | 64 | Value for the conditional-move destination |

## Verification
The checker watches, on every cycle, that the zero register never receives a link write, that the even test follows bit 0 and the equal test follows a zero value, and that unconditional branches are taken and link the incremented PC. It also checks that the direction guess mirrors the displacement sign, that moves and no-ops never redirect, that an aligned PC gives an aligned target, and that outputs hold through idle cycles. The scoreboard scenarios cover what a single property cannot show. These are the full target arithmetic at both ends of the ±4 MiB reach and across address wrap, every signed test at its zero, minus one and extreme operands, move selection with both outcomes, and the reset values.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned XLEN      = 64;
  localparam int unsigned NUM_TESTS = 8;

  typedef enum logic [1:0] {
    KIND_COND = 2'd0,
    KIND_JUMP = 2'd1,
    KIND_CMOV = 2'd2,
    KIND_NONE = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    TST_EQ   = 3'd0,
    TST_NE   = 3'd1,
    TST_LT   = 3'd2,
    TST_LE   = 3'd3,
    TST_GT   = 3'd4,
    TST_GE   = 3'd5,
    TST_EVEN = 3'd6,
    TST_ODD  = 3'd7
  } test_e;
endpackage

// File: rtl/brc_rst_sync.sv
module brc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] value,
  input  test_e        sel,
  output logic         hit
);
  logic                 is_neg;
  logic                 is_zero;
  logic [NUM_TESTS-1:0] hits;

  always_comb begin
    is_neg  = value[W-1];
    is_zero = (value == '0);
    hits[TST_EQ]   = is_zero;
    hits[TST_NE]   = !is_zero;
    hits[TST_LT]   = is_neg;
    hits[TST_LE]   = is_neg || is_zero;
    hits[TST_GT]   = !is_neg && !is_zero;
    hits[TST_GE]   = !is_neg;
    hits[TST_EVEN] = !value[0];
    hits[TST_ODD]  = value[0];
    hit = hits[sel];
  end
endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen #(
  parameter int unsigned W      = 64,
  parameter int unsigned DISP_W = 21,
  parameter int unsigned SCALE  = 2
) (
  input  logic [W-1:0]      next_pc,
  input  logic [DISP_W-1:0] disp,
  output logic [W-1:0]      target,
  output logic              backward
);
  localparam int unsigned EXT_W = W - DISP_W - SCALE;

  logic [W-1:0] offset;

  always_comb begin
    offset   = {{EXT_W{disp[DISP_W-1]}}, disp, {SCALE{1'b0}}};
    target   = next_pc + offset;
    backward = disp[DISP_W-1];
  end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int unsigned DISP_W = 21,
  parameter int unsigned REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [2:0]        in_test,
  input  logic [XLEN-1:0]   in_next_pc,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [XLEN-1:0]   in_test_val,
  input  logic [REG_W-1:0]  in_dest,
  input  logic [XLEN-1:0]   in_move_src,
  input  logic [XLEN-1:0]   in_move_old,
  output logic              out_valid,
  output logic              out_taken,
  output logic [XLEN-1:0]   out_target,
  output logic              out_link_we,
  output logic [XLEN-1:0]   out_link_val,
  output logic              out_pred_taken,
  output logic [XLEN-1:0]   out_move_val
);
  localparam logic [REG_W-1:0] ZERO_REG = {REG_W{1'b1}};

  logic            rst_sync_n;
  op_kind_e        kind;
  test_e           test_sel;
  logic            cond_hit;
  logic [XLEN-1:0] tgt;
  logic            is_backward;

  logic            nxt_taken;
  logic            nxt_link_we;
  logic            nxt_pred;
  logic [XLEN-1:0] nxt_move;

  brc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign kind     = op_kind_e'(in_kind);
  assign test_sel = test_e'(in_test);

  brc_cond_eval #(.W(XLEN)) u_cond (
    .value (in_test_val),
    .sel   (test_sel),
    .hit   (cond_hit)
  );

  brc_target_gen #(.W(XLEN), .DISP_W(DISP_W), .SCALE(2)) u_tgt (
    .next_pc  (in_next_pc),
    .disp     (in_disp),
    .target   (tgt),
    .backward (is_backward)
  );

  // Next-state decode
  always_comb begin
    nxt_taken   = (kind == KIND_JUMP) || ((kind == KIND_COND) && cond_hit);
    nxt_link_we = (kind == KIND_JUMP) && (in_dest != ZERO_REG);
    nxt_pred    = (kind == KIND_JUMP) || ((kind == KIND_COND) && is_backward);
    nxt_move    = ((kind == KIND_CMOV) && cond_hit) ? in_move_src : in_move_old;
  end

  // Valid flag follows the enable every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= in_valid;
  end

  // Result registers, loaded only under in_valid
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_taken      <= 1'b0;
      out_target     <= '0;
      out_link_we    <= 1'b0;
      out_link_val   <= '0;
      out_pred_taken <= 1'b0;
      out_move_val   <= '0;
    end else if (in_valid) begin
      out_taken      <= nxt_taken;
      out_target     <= tgt;
      out_link_we    <= nxt_link_we;
      out_link_val   <= in_next_pc;
      out_pred_taken <= nxt_pred;
      out_move_val   <= nxt_move;
    end
  end
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk
  import brc_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_kind,
  input logic [2:0]        in_test,
  input logic [XLEN-1:0]   in_next_pc,
  input logic              in_disp_sign,
  input logic [XLEN-1:0]   in_test_val,
  input logic [REG_W-1:0]  in_dest,
  input logic [XLEN-1:0]   in_move_old,
  input logic              out_valid,
  input logic              out_taken,
  input logic [XLEN-1:0]   out_target,
  input logic              out_link_we,
  input logic [XLEN-1:0]   out_link_val,
  input logic              out_pred_taken,
  input logic [XLEN-1:0]   out_move_val
);
  localparam logic [REG_W-1:0] ZERO_REG = {REG_W{1'b1}};

  assert_eq_test_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_kind == KIND_COND && in_test == TST_EQ
    |=> out_taken == ($past(in_test_val) == '0));

  assert_even_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_kind == KIND_COND && in_test == TST_EVEN
    |=> out_taken == !$past(in_test_val[0]));

  assert_target_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_next_pc[1:0] == 2'b00 |=> out_target[1:0] == 2'b00);

  assert_jump_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_kind == KIND_JUMP
    |=> out_taken && out_link_val == $past(in_next_pc));

  assert_zero_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_dest == ZERO_REG |=> !out_link_we);

  assert_link_only_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_link_we |-> out_taken);

  assert_back_hint_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_kind == KIND_COND |=> out_pred_taken == $past(in_disp_sign));

  assert_cmov_no_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_kind == KIND_CMOV |=> !out_taken && !out_link_we);

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_taken) && $stable(out_target)
      && $stable(out_link_we) && $stable(out_link_val)
      && $stable(out_pred_taken) && $stable(out_move_val));

  assert_noop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_kind == KIND_NONE
    |=> !out_taken && !out_link_we && !out_pred_taken
      && out_move_val == $past(in_move_old));
endmodule

bind brc_unit brc_unit_chk #(.REG_W(REG_W)) i_brc_unit_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .in_valid       (in_valid),
  .in_kind        (in_kind),
  .in_test        (in_test),
  .in_next_pc     (in_next_pc),
  .in_disp_sign   (in_disp[DISP_W-1]),
  .in_test_val    (in_test_val),
  .in_dest        (in_dest),
  .in_move_old    (in_move_old),
  .out_valid      (out_valid),
  .out_taken      (out_taken),
  .out_target     (out_target),
  .out_link_we    (out_link_we),
  .out_link_val   (out_link_val),
  .out_pred_taken (out_pred_taken),
  .out_move_val   (out_move_val)
);

// File: tb/test_brc_unit.sv
module test_brc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_kind;
  logic [2:0]  in_test;
  logic [63:0] in_next_pc;
  logic [20:0] in_disp;
  logic [63:0] in_test_val;
  logic [4:0]  in_dest;
  logic [63:0] in_move_src;
  logic [63:0] in_move_old;
  logic        out_valid;
  logic        out_taken;
  logic [63:0] out_target;
  logic        out_link_we;
  logic [63:0] out_link_val;
  logic        out_pred_taken;
  logic [63:0] out_move_val;

  typedef struct packed {
    logic        taken;
    logic [63:0] target;
    logic        link_we;
    logic [63:0] link_val;
    logic        pred;
    logic [63:0] move_val;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  last_exp;
  bit    have_last = 0;
  int    n_checks = 0;
  int    n_fails = 0;
  bit    done = 0;

  always #2 clk = ~clk;

  brc_unit i_brc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_test(in_test), .in_next_pc(in_next_pc), .in_disp(in_disp),
    .in_test_val(in_test_val), .in_dest(in_dest), .in_move_src(in_move_src),
    .in_move_old(in_move_old), .out_valid(out_valid), .out_taken(out_taken),
    .out_target(out_target), .out_link_we(out_link_we),
    .out_link_val(out_link_val), .out_pred_taken(out_pred_taken),
    .out_move_val(out_move_val)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  function automatic bit test_true(input logic [2:0] t, input logic [63:0] v);
    longint sv = longint'(v);
    case (t)
      3'd0: return sv == 0;
      3'd1: return sv != 0;
      3'd2: return sv < 0;
      3'd3: return sv <= 0;
      3'd4: return sv > 0;
      3'd5: return sv >= 0;
      3'd6: return (v % 2) == 0;
      default: return (v % 2) == 1;
    endcase
  endfunction

  function automatic bit check_one(input string tag, input bit vld_exp, input exp_t e);
    bit ok;
    ok = (out_valid === vld_exp) && (out_taken === e.taken) && (out_target === e.target)
      && (out_link_we === e.link_we) && (out_link_val === e.link_val)
      && (out_pred_taken === e.pred) && (out_move_val === e.move_val);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: valid %0b/%0b taken %0b/%0b target %h/%h link_we %0b/%0b link %h/%h pred %0b/%0b move %h/%h",
               tag, out_valid, vld_exp, out_taken, e.taken, out_target, e.target,
               out_link_we, e.link_we, out_link_val, e.link_val,
               out_pred_taken, e.pred, out_move_val, e.move_val);
    end
    return ok;
  endfunction

  // Driver: compute expectation from the requirements, queue it, drive inputs
  task automatic send(input logic [1:0] k, input logic [2:0] t, input logic [63:0] pc,
                      input logic [20:0] d, input logic [63:0] v, input logic [4:0] dst,
                      input logic [63:0] src, input logic [63:0] old, input string tag);
    exp_t   e;
    bit     hit;
    longint off;
    hit = test_true(t, v);
    off = longint'($signed(d)) * 4;
    e.taken    = (k == 2'd1) || (k == 2'd0 && hit);
    e.target   = pc + 64'(off);
    e.link_we  = (k == 2'd1) && (dst != 5'd31);
    e.link_val = pc;
    e.pred     = (k == 2'd1) || (k == 2'd0 && off < 0);
    e.move_val = (k == 2'd2 && hit) ? src : old;
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    in_valid = 1'b1; in_kind = k; in_test = t; in_next_pc = pc; in_disp = d;
    in_test_val = v; in_dest = dst; in_move_src = src; in_move_old = old;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_kind = 2'($urandom_range(0, 3)); in_test = 3'($urandom_range(0, 7));
    in_next_pc = {$urandom, $urandom}; in_disp = 21'($urandom);
    in_test_val = {$urandom, $urandom}; in_dest = 5'($urandom);
    in_move_src = {$urandom, $urandom}; in_move_old = {$urandom, $urandom};
  endtask

  // Monitor: pop and compare one cycle after each accepted input
  always @(posedge clk) begin
    if (rst_n && in_valid) begin
      #1;
      if (exp_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL R8: result 1/0 with empty scoreboard");
      end else begin
        last_exp = exp_q.pop_front();
        void'(check_one(tag_q.pop_front(), 1'b1, last_exp));
        have_last = 1;
      end
    end else if (rst_n && have_last && !done) begin
      #1;
      void'(check_one("R8 hold while idle", 1'b0, last_exp));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: finished 0/1");
    summary();
  end

  initial begin
    exp_t zero_e;
    zero_e = '0;
    rst_n = 1'b0;
    in_valid = 1'b0; in_kind = 2'd0; in_test = 3'd0; in_next_pc = '0; in_disp = '0;
    in_test_val = '0; in_dest = '0; in_move_src = '0; in_move_old = '0;
    repeat (3) @(negedge clk);
    void'(check_one("R9 outputs during reset", 1'b0, zero_e));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    void'(check_one("R9 outputs after reset release", 1'b0, zero_e));

    // R1 signed tests at zero, minus one and extremes
    send(2'd0, 3'd0, 64'h1000, 21'd4, 64'd0, 5'd3, 64'd0, 64'd0, "R1 EQ zero");
    send(2'd0, 3'd0, 64'h1000, 21'd4, 64'd5, 5'd3, 64'd0, 64'd0, "R1 EQ nonzero");
    send(2'd0, 3'd1, 64'h2000, 21'd8, '1, 5'd3, 64'd0, 64'd0, "R1 NE minus one");
    send(2'd0, 3'd2, 64'h2000, 21'd8, '1, 5'd3, 64'd0, 64'd0, "R1 LT minus one");
    send(2'd0, 3'd2, 64'h2000, 21'd8, 64'd0, 5'd3, 64'd0, 64'd0, "R1 LT zero");
    send(2'd0, 3'd3, 64'h2000, 21'd8, 64'd0, 5'd3, 64'd0, 64'd0, "R1 LE zero");
    send(2'd0, 3'd4, 64'h2000, 21'd8, 64'd0, 5'd3, 64'd0, 64'd0, "R1 GT zero");
    send(2'd0, 3'd4, 64'h2000, 21'd8, 64'd1, 5'd3, 64'd0, 64'd0, "R1 GT one");
    send(2'd0, 3'd5, 64'h2000, 21'd8, 64'h8000_0000_0000_0000, 5'd3, 64'd0, 64'd0, "R1 GE most negative");
    send(2'd0, 3'd5, 64'h2000, 21'd8, 64'h7FFF_FFFF_FFFF_FFFF, 5'd3, 64'd0, 64'd0, "R1 GE most positive");
    // R2 parity tests ignore the upper bits
    send(2'd0, 3'd6, 64'h3000, 21'd1, 64'h8000_0000_0000_0001, 5'd0, 64'd0, 64'd0, "R2 EVEN odd negative");
    send(2'd0, 3'd6, 64'h3000, 21'd1, 64'd6, 5'd0, 64'd0, 64'd0, "R2 EVEN six");
    send(2'd0, 3'd7, 64'h3000, 21'd1, 64'hFFFF_FFFF_FFFF_FFFE, 5'd0, 64'd0, 64'd0, "R2 ODD even negative");
    send(2'd0, 3'd7, 64'h3000, 21'd1, 64'd3, 5'd0, 64'd0, 64'd0, "R2 ODD three");
    // R3 reach ends and wrap, R6 direction hint
    send(2'd0, 3'd0, 64'h0100_0000, 21'h0F_FFFF, 64'd0, 5'd1, 64'd0, 64'd0, "R3 R6 max forward reach");
    send(2'd0, 3'd0, 64'h0100_0000, 21'h10_0000, 64'd0, 5'd1, 64'd0, 64'd0, "R3 R6 max backward reach");
    send(2'd0, 3'd1, 64'h0000_0004, 21'h1F_FFFE, 64'd0, 5'd1, 64'd0, 64'd0, "R3 R6 backward wrap below zero");
    send(2'd0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFC, 21'd1, 64'd0, 5'd1, 64'd0, 64'd0, "R3 forward wrap past top");
    send(2'd0, 3'd0, 64'h4000, 21'd0, 64'd0, 5'd1, 64'd0, 64'd0, "R6 zero displacement not backward");
    // R4/R5 unconditional branch and link suppression
    send(2'd1, 3'd0, 64'h0000_8000_0000_1234, 21'h1F_FFF0, 64'd9, 5'd26, 64'd0, 64'hAA, "R4 R5 R6 jump links to r26");
    send(2'd1, 3'd3, 64'h5008, 21'd16, 64'd9, 5'd31, 64'd0, 64'hAA, "R5 jump link to zero register dropped");
    send(2'd0, 3'd0, 64'h5008, 21'd16, 64'd0, 5'd7, 64'd0, 64'hAA, "R5 conditional taken never links");
    // R7 conditional moves
    send(2'd2, 3'd0, 64'h6000, 21'h10_0000, 64'd0, 5'd4, 64'h1111, 64'h2222, "R7 cmov true selects source");
    send(2'd2, 3'd7, 64'h6000, 21'h10_0000, 64'd8, 5'd4, 64'h1111, 64'h2222, "R7 cmov false keeps old");
    // R10 no-op
    send(2'd3, 3'd0, 64'h7000, 21'h10_0000, 64'd0, 5'd4, 64'h1111, 64'h3333, "R10 no-op kind");
    // R8 idle hold with scrambled inputs
    idle(); idle(); idle();
    send(2'd1, 3'd0, 64'h9000, 21'd2, 64'd0, 5'd31, 64'd0, 64'd0, "R8 resume after idle");
    idle();

    for (int i = 0; i < 80; i++) begin
      logic [63:0] v;
      v = (i % 5 == 0) ? 64'd0 : {$urandom, $urandom};
      send(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
           {$urandom, $urandom} & ~64'd3, 21'($urandom), v, 5'($urandom_range(0, 31)),
           {$urandom, $urandom}, {$urandom, $urandom}, "R1/R2/R3/R4/R5/R6/R7/R10 mixed");
      if (i % 7 == 3) idle();
    end
    idle();
    @(negedge clk);
    done = 1;
    @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R8: leftover results %0d/0", exp_q.size());
    end
    summary();
  end
endmodule